// File: doc/BRIEF.md
# Timer Channel Register Access Unit

This block is the bus-facing half of one channel of a programmable interval timer. It takes control words and count bytes from an 8-bit bus, holds the programmed access format, mode and number-system bit, stages a new 16-bit count in a two-half count register and hands it to the counting element as one transfer. It also serves reads of the channel: the live count, a frozen copy of the count, or a status byte. Bytes are sequenced according to the programmed access format.

The write and read strobes are active-low and synchronous to `clk`. A write takes effect when its strobe returns high. A read completes, and advances the byte sequence, when its strobe returns high. While a read is in progress, `dout` shows the byte that read returns. The counting element supplies the live count, the OUT level and a one-cycle pulse when it has taken a staged count. The down-counter and the OUT waveforms are outside this block.

Top module: `tmr_acc_unit`

## Requirements
- R1: After reset the format is LSB only, mode 0, binary, the null-count flag is 0, no transfer is pending and `dout` shows the low byte of the live count.
- R2: A control word whose bits 7:6 equal this channel's number (0) and whose bits 5:4 are not 00 stores bits 5:4 as format (01 LSB only, 10 MSB only, 11 LSB then MSB), bits 3:1 as mode and bit 0 as BCD select. Control words for another channel number leave the configuration unchanged.
- R3: In a single-byte format, each count write makes `ld_pulse` high for one cycle, one cycle after the write strobe rises, with `ld_val` = {00, byte} for LSB only and {byte, 00} for MSB only.
- R4: In two-byte format the first write gives no transfer, and the second gives one transfer of {second byte, first byte}.
- R5: Programming the channel clears both count-register halves and restarts the write and read byte sequences at the low byte.
- R6: The null-count flag is set by every transfer and cleared by the `load_done` pulse. When both happen in the same cycle, the flag is set.
- R7: A counter-latch command (bits 7:6 = channel, bits 5:4 = 00) freezes the live count. Reads return the frozen value until it has been fully read in the programmed format, and then return the live count.
- R8: A count-latch request while a frozen count is still unread has no effect.
- R9: A read-back with bit 4 low captures status {OUT, null flag, format[1:0], mode[2:0], BCD} (bits 7..0). A second status capture before that status is read has no effect.
- R10: When both status and count are latched, the first read returns status, whichever was latched first. The following reads return the frozen count.
- R11: In two-byte format, successive reads return the low byte and then the high byte.
- R12: A read-back command (bits 7:6 = 11) acts only when its select bit 1 (channel 0) is set. Bit 5 low requests a count latch and bit 4 low requests a status latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe, takes effect on its rising edge |
| rd_n | input | 1 | Active-low read strobe, read completes on its rising edge |
| cs_cnt | input | 1 | Selects this channel's count data port |
| cs_ctl | input | 1 | Selects the shared control word port |
| din | input | 8 | Write data |
| live_cnt | input | 16 | Current value of the counting element |
| out_lvl | input | 1 | Current OUT level of the channel |
| load_done | input | 1 | One-cycle pulse when the counting element takes a staged count |
| dout | output | 8 | Byte returned by a read of the count port |
| ld_pulse | output | 1 | One-cycle transfer of a staged count |
| ld_val | output | 16 | Staged count, valid with `ld_pulse` |
| null_cnt | output | 1 | A written count has not yet been taken by the counting element |
| cfg_mode | output | 3 | Programmed mode |
| cfg_bcd | output | 1 | Programmed BCD select |

## Verification
Two pairs of events can land on the same clock edge. The first is the transfer that sets the null-count flag and the `load_done` pulse that clears it. The bench raises `load_done` in exactly the cycle in which the second byte of a two-byte count is committed, and expects the flag to read 1 afterwards. The second pair is a status latch and a count latch made in either order. Both orders are provoked on purpose, and random read-back commands mixed with reads provoke them again. Every read is compared with a bench model that serves status first, then the frozen count, then the live count.

// File: rtl/tmr_acc_pkg.sv
// Shared widths and types for the timer channel register access unit.
package tmr_acc_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    // Byte access format held in the configuration.
    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_LSB   = 2'b01,
        FMT_MSB   = 2'b10,
        FMT_BOTH  = 2'b11
    } acc_fmt_t;

    // Programmed channel configuration (6 bits, status byte order).
    typedef struct packed {
        acc_fmt_t          fmt;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ch_cfg_t;
endpackage

// File: rtl/tmr_ctl_decode.sv
// Control word decoder.
// Turns one committed control word into per-channel requests: program this
// channel, latch its count, latch its status. Assumes ctl_wr is a one-cycle
// commit and cw is stable in that cycle. Purely combinational.
module tmr_ctl_decode
    import tmr_acc_pkg::*;
#(
    parameter int CNT_ID = 0
) (
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] cw,
    output logic              prog,
    output ch_cfg_t           cfg_new,
    output logic              lat_cnt_req,
    output logic              lat_sts_req
);
    localparam logic [1:0] SC_ID = 2'(CNT_ID);
    localparam logic [1:0] SC_RB = 2'b11;

    logic own_sel;
    logic rb_hit;

    // Field decode of the control word.
    always_comb begin
        own_sel     = (cw[7:6] == SC_ID);
        rb_hit      = (cw[7:6] == SC_RB) && cw[1 + CNT_ID];
        prog        = ctl_wr && own_sel && (cw[5:4] != 2'b00);
        lat_cnt_req = ctl_wr && ((own_sel && (cw[5:4] == 2'b00)) || (rb_hit && !cw[5]));
        lat_sts_req = ctl_wr && rb_hit && !cw[4];
        cfg_new     = '{fmt: acc_fmt_t'(cw[5:4]), mode: cw[3:1], bcd: cw[0]};
    end
endmodule

// File: rtl/tmr_wr_seq.sv
// Count write sequencer.
// Stages count bytes into two register halves per the access format, issues
// a one-cycle transfer of the full value and tracks the null-count flag.
// Assumes prog and cnt_wr never coincide and load_done is a one-cycle pulse.
module tmr_wr_seq
    import tmr_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              cnt_wr,
    input  logic [BYTE_W-1:0] din,
    input  acc_fmt_t          fmt,
    input  logic              load_done,
    output logic              ld_pulse,
    output logic [CNT_W-1:0]  ld_val,
    output logic              null_cnt
);
    logic [BYTE_W-1:0] cr_lo;
    logic [BYTE_W-1:0] cr_hi;
    logic              wr_hi;
    logic              ld_fire;

    // A write completes a count in single-byte formats or on the second byte.
    always_comb begin
        ld_fire = cnt_wr && ((fmt == FMT_LSB) || (fmt == FMT_MSB) ||
                             ((fmt == FMT_BOTH) && wr_hi));
    end

    // Count register halves and the write byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_lo <= '0;
            cr_hi <= '0;
            wr_hi <= 1'b0;
        end else if (prog) begin
            cr_lo <= '0;
            cr_hi <= '0;
            wr_hi <= 1'b0;
        end else if (cnt_wr) begin
            case (fmt)
                FMT_LSB: begin
                    cr_lo <= din;
                    cr_hi <= '0;
                end
                FMT_MSB: begin
                    cr_hi <= din;
                    cr_lo <= '0;
                end
                FMT_BOTH: begin
                    if (!wr_hi) cr_lo <= din;
                    else        cr_hi <= din;
                    wr_hi <= !wr_hi;
                end
                default: ;
            endcase
        end
    end

    // One-cycle transfer strobe towards the counting element.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_pulse <= 1'b0;
        else        ld_pulse <= ld_fire;
    end

    // Null-count flag: a new transfer wins over a simultaneous load_done.
    always_ff @(posedge clk) begin
        if (!rst_n)         null_cnt <= 1'b0;
        else if (ld_fire)   null_cnt <= 1'b1;
        else if (load_done) null_cnt <= 1'b0;
    end

    assign ld_val = {cr_hi, cr_lo};

    p_lsb_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && (fmt == FMT_LSB) |=> ld_pulse && (ld_val == {{BYTE_W{1'b0}}, $past(din)}));
    p_msb_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && (fmt == FMT_MSB) |=> ld_pulse && (ld_val == {$past(din), {BYTE_W{1'b0}}}));
    p_pulse_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse |-> $past(cnt_wr));
    p_null_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse |-> null_cnt);
    p_null_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_done && !cnt_wr |=> !null_cnt);
endmodule

// File: rtl/tmr_rd_seq.sv
// Read sequencer.
// Holds the frozen count and the captured status, selects the byte a read
// returns (status, then frozen count, then live count) and advances the read
// byte pointer when a read completes. Assumes latch requests and read
// completions never fall in the same cycle.
module tmr_rd_seq
    import tmr_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              lat_cnt_req,
    input  logic              lat_sts_req,
    input  logic              rd_done,
    input  acc_fmt_t          fmt,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic [BYTE_W-1:0] sts_byte,
    output logic [BYTE_W-1:0] dout
);
    logic [CNT_W-1:0]  ol_q;
    logic              cnt_lat;
    logic [BYTE_W-1:0] sts_q;
    logic              sts_lat;
    logic              rd_hi;
    logic [CNT_W-1:0]  cur;
    logic              last_byte;

    // Byte the next read returns.
    always_comb begin
        cur       = cnt_lat ? ol_q : live_cnt;
        last_byte = (fmt != FMT_BOTH) || rd_hi;
        if (sts_lat)
            dout = sts_q;
        else if ((fmt == FMT_MSB) || ((fmt == FMT_BOTH) && rd_hi))
            dout = cur[CNT_W-1:BYTE_W];
        else
            dout = cur[BYTE_W-1:0];
    end

    // Frozen count and read byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ol_q    <= '0;
            cnt_lat <= 1'b0;
            rd_hi   <= 1'b0;
        end else if (prog) begin
            cnt_lat <= 1'b0;
            rd_hi   <= 1'b0;
        end else begin
            if (lat_cnt_req && !cnt_lat) begin
                ol_q    <= live_cnt;
                cnt_lat <= 1'b1;
            end
            if (rd_done && !sts_lat) begin
                if (fmt == FMT_BOTH)      rd_hi   <= !rd_hi;
                if (last_byte && cnt_lat) cnt_lat <= 1'b0;
            end
        end
    end

    // Captured status, consumed by the first read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q   <= '0;
            sts_lat <= 1'b0;
        end else if (prog) begin
            sts_lat <= 1'b0;
        end else if (lat_sts_req && !sts_lat) begin
            sts_q   <= sts_byte;
            sts_lat <= 1'b1;
        end else if (rd_done && sts_lat) begin
            sts_lat <= 1'b0;
        end
    end

    p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_lat |=> $stable(ol_q));
    p_unlatch_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_lat && !sts_lat && rd_done && last_byte && !prog |=> !cnt_lat);
    p_sts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sts_lat && !rd_done && !prog |=> sts_lat && $stable(sts_q));
    p_sts_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sts_lat && rd_done && !prog |=> !sts_lat && $stable(cnt_lat) && $stable(rd_hi));
endmodule

// File: rtl/tmr_acc_unit.sv
// Timer channel register access unit (top).
// Detects strobe edges, holds the channel configuration and ties together
// the control decoder, the count write sequencer and the read sequencer.
// Assumes wr_n, rd_n and the selects are synchronous to clk, and that the
// selects and din are stable while a strobe is low.
module tmr_acc_unit
    import tmr_acc_pkg::*;
#(
    parameter int CNT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cs_cnt,
    input  logic              cs_ctl,
    input  logic [BYTE_W-1:0] din,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    input  logic              load_done,
    output logic [BYTE_W-1:0] dout,
    output logic              ld_pulse,
    output logic [CNT_W-1:0]  ld_val,
    output logic              null_cnt,
    output logic [MODE_W-1:0] cfg_mode,
    output logic              cfg_bcd
);
    logic              wr_n_q;
    logic              rd_n_q;
    logic [BYTE_W-1:0] din_q;
    logic              wsel_cnt_q;
    logic              wsel_ctl_q;
    logic              rsel_q;
    logic              wr_commit;
    logic              ctl_wr;
    logic              cnt_wr;
    logic              rd_done;
    logic              prog;
    logic              lat_cnt_req;
    logic              lat_sts_req;
    ch_cfg_t           cfg_new;
    ch_cfg_t           cfg_q;
    logic [BYTE_W-1:0] sts_byte;

    // Strobe history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_n_q <= 1'b1;
            rd_n_q <= 1'b1;
        end else begin
            wr_n_q <= wr_n;
            rd_n_q <= rd_n;
        end
    end

    // Capture write data and selects while the write strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q      <= '0;
            wsel_cnt_q <= 1'b0;
            wsel_ctl_q <= 1'b0;
        end else if (!wr_n) begin
            din_q      <= din;
            wsel_cnt_q <= cs_cnt;
            wsel_ctl_q <= cs_ctl;
        end
    end

    // Capture the read select while the read strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n)     rsel_q <= 1'b0;
        else if (!rd_n) rsel_q <= cs_cnt;
    end

    // Commit events on the rising edge of each strobe.
    always_comb begin
        wr_commit = !wr_n_q && wr_n;
        ctl_wr    = wr_commit && wsel_ctl_q;
        cnt_wr    = wr_commit && wsel_cnt_q && !wsel_ctl_q;
        rd_done   = !rd_n_q && rd_n && rsel_q;
    end

    // Channel configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= '{fmt: FMT_LSB, mode: '0, bcd: 1'b0};
        else if (prog) cfg_q <= cfg_new;
    end

    assign sts_byte = {out_lvl, null_cnt, cfg_q};
    assign cfg_mode = cfg_q.mode;
    assign cfg_bcd  = cfg_q.bcd;

    tmr_ctl_decode #(.CNT_ID(CNT_ID)) u_dec (
        .ctl_wr      (ctl_wr),
        .cw          (din_q),
        .prog        (prog),
        .cfg_new     (cfg_new),
        .lat_cnt_req (lat_cnt_req),
        .lat_sts_req (lat_sts_req)
    );

    tmr_wr_seq u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog      (prog),
        .cnt_wr    (cnt_wr),
        .din       (din_q),
        .fmt       (cfg_q.fmt),
        .load_done (load_done),
        .ld_pulse  (ld_pulse),
        .ld_val    (ld_val),
        .null_cnt  (null_cnt)
    );

    tmr_rd_seq u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog        (prog),
        .lat_cnt_req (lat_cnt_req),
        .lat_sts_req (lat_sts_req),
        .rd_done     (rd_done),
        .fmt         (cfg_q.fmt),
        .live_cnt    (live_cnt),
        .sts_byte    (sts_byte),
        .dout        (dout)
    );

    p_cfg_only_on_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog |=> $stable(cfg_q));
    p_cfg_never_latch_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (cfg_q.fmt != FMT_LATCH));
endmodule

// File: tb/tmr_acc_unit_tb.sv
module tmr_acc_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        cs_cnt = 1'b0;
    logic        cs_ctl = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [15:0] live_cnt = 16'h0000;
    logic        out_lvl = 1'b0;
    logic        load_done = 1'b0;
    logic [7:0]  dout;
    logic        ld_pulse;
    logic [15:0] ld_val;
    logic        null_cnt;
    logic [2:0]  cfg_mode;
    logic        cfg_bcd;

    int n_chk = 0;
    int n_fail = 0;
    logic        obs_ld;
    logic [15:0] obs_val;

    // Bench model of the channel.
    logic [1:0]  m_fmt = 2'b01;
    logic [2:0]  m_mode = 3'd0;
    logic        m_bcd = 1'b0;
    logic        m_whi = 1'b0;
    logic [7:0]  m_lo = 8'h00;
    logic        m_null = 1'b0;
    logic        m_cl = 1'b0;
    logic [15:0] m_ol = 16'h0000;
    logic        m_sl = 1'b0;
    logic [7:0]  m_sts = 8'h00;
    logic        m_rhi = 1'b0;

    always #(CLK_PERIOD / 2) clk = !clk;

    tmr_acc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
        .cs_cnt(cs_cnt), .cs_ctl(cs_ctl), .din(din), .live_cnt(live_cnt),
        .out_lvl(out_lvl), .load_done(load_done), .dout(dout),
        .ld_pulse(ld_pulse), .ld_val(ld_val), .null_cnt(null_cnt),
        .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic is_ctl, input logic [7:0] d, input logic with_ld);
        @(negedge clk);
        cs_ctl = is_ctl; cs_cnt = !is_ctl; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; load_done = with_ld;
        @(negedge clk);
        load_done = 1'b0; cs_ctl = 1'b0; cs_cnt = 1'b0;
        obs_ld = ld_pulse; obs_val = ld_val;
    endtask

    task automatic bus_read(output logic [7:0] v);
        @(negedge clk);
        cs_cnt = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        v = dout; rd_n = 1'b1;
        @(negedge clk);
        cs_cnt = 1'b0;
    endtask

    function automatic logic [7:0] status_of(input logic ol);
        return {ol, m_null, m_fmt, m_mode, m_bcd};
    endfunction

    task automatic do_program(input logic [1:0] f, input logic [2:0] md, input logic b);
        bus_write(1'b1, {2'b00, f, md, b}, 1'b0);
        m_fmt = f; m_mode = md; m_bcd = b;
        m_whi = 1'b0; m_lo = 8'h00; m_cl = 1'b0; m_sl = 1'b0; m_rhi = 1'b0;
        chk("R2 no transfer on program", {15'd0, obs_ld}, 16'd0);
        chk("R2 mode/bcd outputs", {12'd0, cfg_mode, cfg_bcd}, {12'd0, md, b});
    endtask

    task automatic do_wr_count(input logic [7:0] b, input logic with_ld, input string tag);
        logic        e_ld;
        logic [15:0] e_val;
        e_ld = 1'b0; e_val = 16'h0;
        case (m_fmt)
            2'b01: begin e_ld = 1'b1; e_val = {8'h00, b}; end
            2'b10: begin e_ld = 1'b1; e_val = {b, 8'h00}; end
            2'b11: begin
                if (!m_whi) m_lo = b;
                else begin e_ld = 1'b1; e_val = {b, m_lo}; end
                m_whi = !m_whi;
            end
            default: ;
        endcase
        bus_write(1'b0, b, with_ld);
        if (e_ld) m_null = 1'b1;
        else if (with_ld) m_null = 1'b0;
        chk(tag, {15'd0, obs_ld}, {15'd0, e_ld});
        if (e_ld) chk(tag, obs_val, e_val);
        chk("R6 null flag after write", {15'd0, null_cnt}, {15'd0, m_null});
    endtask

    task automatic do_latch();
        bus_write(1'b1, {2'b00, 2'b00, 4'($urandom_range(0, 15))}, 1'b0);
        if (!m_cl) begin m_cl = 1'b1; m_ol = live_cnt; end
    endtask

    task automatic do_readback(input logic cnt_n, input logic sts_n, input logic [2:0] mask);
        bus_write(1'b1, {2'b11, cnt_n, sts_n, mask, 1'b0}, 1'b0);
        if (mask[0]) begin
            if (!cnt_n && !m_cl) begin m_cl = 1'b1; m_ol = live_cnt; end
            if (!sts_n && !m_sl) begin m_sl = 1'b1; m_sts = status_of(out_lvl); end
        end
    endtask

    task automatic do_read(input string tag);
        logic [7:0]  v;
        logic [7:0]  e;
        logic [15:0] cur;
        if (m_sl) begin
            e = m_sts; m_sl = 1'b0;
        end else begin
            cur = m_cl ? m_ol : live_cnt;
            if (m_fmt == 2'b10) e = cur[15:8];
            else if (m_fmt == 2'b11 && m_rhi) e = cur[15:8];
            else e = cur[7:0];
            if (m_fmt == 2'b11) begin
                if (m_rhi) m_cl = 1'b0;
                m_rhi = !m_rhi;
            end else begin
                m_cl = 1'b0;
            end
        end
        bus_read(v);
        chk(tag, {8'd0, v}, {8'd0, e});
    endtask

    task automatic do_load_done();
        @(negedge clk);
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
        m_null = 1'b0;
        chk("R6 load_done clears null", {15'd0, null_cnt}, 16'd0);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live_cnt = 16'hC3A5;
        @(negedge clk);
        // R1 reset state
        chk("R1 null after reset", {15'd0, null_cnt}, 16'd0);
        chk("R1 no transfer after reset", {15'd0, ld_pulse}, 16'd0);
        chk("R1 dout low live byte", {8'd0, dout}, 16'h00A5);
        chk("R1 mode and bcd", {12'd0, cfg_mode, cfg_bcd}, 16'd0);

        // R3 single-byte formats
        do_program(2'b01, 3'd2, 1'b0);
        do_wr_count(8'h5A, 1'b0, "R3 lsb-only transfer");
        chk("R3 literal lsb value", obs_val, 16'h005A);
        do_load_done();
        do_program(2'b10, 3'd3, 1'b1);
        do_wr_count(8'h3C, 1'b0, "R3 msb-only transfer");
        chk("R3 literal msb value", obs_val, 16'h3C00);

        // R4 two-byte write
        do_program(2'b11, 3'd0, 1'b0);
        do_wr_count(8'h11, 1'b0, "R4 first byte no transfer");
        do_wr_count(8'h22, 1'b0, "R4 second byte transfer");
        chk("R4 literal pair", obs_val, 16'h2211);

        // R5 reprogram mid-sequence restarts at low byte
        do_wr_count(8'h33, 1'b0, "R5 partial write");
        do_program(2'b11, 3'd1, 1'b0);
        do_wr_count(8'h44, 1'b0, "R5 first after reprogram");
        do_wr_count(8'h55, 1'b0, "R5 second after reprogram");
        chk("R5 literal pair", obs_val, 16'h5544);

        // R6 transfer and load_done in the same cycle
        do_load_done();
        do_wr_count(8'h66, 1'b0, "R6 setup byte");
        do_wr_count(8'h77, 1'b1, "R6 collision transfer");
        chk("R6 set wins over load_done", {15'd0, null_cnt}, 16'd1);

        // R7 R8 R11 latch, ignored relatch, byte order
        live_cnt = 16'h1234;
        do_latch();
        live_cnt = 16'hABCD;
        do_latch();
        do_read("R8 relatch ignored, low byte");
        live_cnt = 16'h9999;
        do_read("R11 high byte of frozen count");
        do_read("R7 live after full read");
        do_read("R11 live high byte");

        // R10 count latched first, status second
        out_lvl = 1'b1;
        live_cnt = 16'h0F0E;
        do_readback(1'b0, 1'b1, 3'b001);
        live_cnt = 16'h7777;
        do_readback(1'b1, 1'b0, 3'b001);
        out_lvl = 1'b0;
        do_readback(1'b1, 1'b0, 3'b001);
        do_read("R10 status first");
        do_read("R10 frozen low after status");
        do_read("R10 frozen high after status");

        // R9 status bits literal
        do_readback(1'b1, 1'b0, 3'b001);
        do_read("R9 status capture");
        chk("R9 status literal", {8'd0, m_sts}, {8'd0, 1'b0, null_cnt, 2'b11, 3'd1, 1'b0});

        // R2 R12 other channel and unselected read-back
        bus_write(1'b1, 8'b01_01_010_1, 1'b0);
        chk("R2 other channel ignored", {12'd0, cfg_mode, cfg_bcd}, {12'd0, m_mode, m_bcd});
        live_cnt = 16'h4321;
        do_readback(1'b0, 1'b0, 3'b110);
        live_cnt = 16'h8765;
        do_read("R12 unselected read-back, live low");
        do_read("R12 unselected read-back, live high");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: do_program(2'($urandom_range(1, 3)), 3'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
                1, 2: do_wr_count(8'($urandom_range(0, 255)), 1'($urandom_range(0, 3) == 0), "R4 random write");
                3: do_latch();
                4: begin
                    out_lvl = 1'($urandom_range(0, 1));
                    do_readback(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
                end
                5, 6: do_read("R10 random read");
                7: do_load_done();
                8: live_cnt = 16'($urandom_range(0, 65535));
                default: begin
                    bus_write(1'b1, {2'b10, 6'($urandom_range(0, 63))}, 1'b0);
                    chk("R2 random other channel", {12'd0, cfg_mode, cfg_bcd}, {12'd0, m_mode, m_bcd});
                end
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule